// File: doc/BRIEF.md
# Two-Wire EEPROM Command Slave

This block sits behind the two pins of a serial memory and turns the bus traffic into memory accesses. SCL and SDA are first brought into the system clock domain and sampled, and the block then finds start and stop conditions on the sampled lines. A state machine receives the device byte, the word address and the data bytes. For a write it emits one commit strobe per data byte toward a separate write engine. For a read it fetches bytes from a same-cycle read port and shifts them out MSB first. The block only ever pulls SDA low, through an active-low enable; the pad and the pull-up sit outside it.

A 9-bit address counter holds the last accessed location plus one. Its top bit comes from the device byte of a write and its lower eight bits from the word-address byte. During a write, only the four low bits advance, so a burst stays inside its 16-byte page. During a read, the whole counter advances and passes from 511 back to 0.

States: `ST_IDLE` (waiting for a start), `ST_DEV` (receiving the device byte), `ST_DEV_ACK` (acknowledging it), `ST_WADDR` / `ST_WADDR_ACK` (word address and its acknowledge), `ST_WDATA` / `ST_WDATA_ACK` (write data and its acknowledge), `ST_RDATA` (sending a byte) and `ST_RACK` (listening for the master's acknowledge). The transitions are as follows:
- A start in any state goes to `ST_DEV`, and a stop in any state goes to `ST_IDLE`.
- When the device byte is complete, a matching byte goes to `ST_DEV_ACK` and any other byte goes to `ST_IDLE`.
- At the end of `ST_DEV_ACK`, a read goes to `ST_RDATA` and a write goes to `ST_WADDR`.
- `ST_WADDR` goes to `ST_WADDR_ACK`, which goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RACK`. From there an acknowledge goes back to `ST_RDATA` and a missing acknowledge goes to `ST_IDLE`.

Top module: `eep2w_slave`

## Requirements
- R1: SDA falling while SCL is high (start) in any state restarts reception of a device byte from its first bit. SDA rising while SCL is high (stop) returns the block to idle with SDA released.
- R2: The device byte is sent MSB first. Bits 7..4 are 1010, bit 3 must equal strap_a2, bit 2 must equal strap_a1, bit 1 is memory address bit 8, and bit 0 selects read (1) or write (0). On a match, SDA is held low during the ninth clock.
- R3: A device byte that does not match is not acknowledged. The bytes that follow it are ignored until the next start: no acknowledge, no write strobe and no change to the address counter.
- R4: A write is made of a device byte with bit 0 = 0, a word-address byte (address bits 7..0) and a data byte. Every byte is acknowledged. The data byte produces exactly one single-cycle wr_en, with wr_addr = {device bit 1, word address} and wr_data = the byte.
- R5: Each further data byte in the same write goes to the next address, with only address bits 3..0 incremented. After offset 15 the address wraps to offset 0 of the same page, and bits 8..4 keep their value.
- R6: The counter holds the last accessed address plus one. It resets to 0. A read started directly returns the byte at the counter. Bit 1 of a read device byte does not alter the counter.
- R7: A random read returns the byte at the loaded address and produces no write strobe. It consists of a write device byte and a word address, then a repeated start and a read device byte.
- R8: When the master acknowledges a read byte, the next byte follows. The read address advances over the whole array and wraps from 511 to 0.
- R9: When the master does not acknowledge a read byte, SDA stays released until the next start. The counter still points one past the last byte sent.
- R10: Incoming bits are taken at the SCL rising edge. The block starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_n | output | 1 | Low pulls SDA to ground; high releases it |
| strap_a2 | input | 1 | Board strap compared with device byte bit 3 |
| strap_a1 | input | 1 | Board strap compared with device byte bit 2 |
| mem_rd_addr | output | 9 | Read port address (the address counter) |
| mem_rd_data | input | 8 | Read port data, valid in the same cycle as its address |
| wr_en | output | 1 | One-cycle commit strobe per received data byte |
| wr_addr | output | 9 | Address for the commit |
| wr_data | output | 8 | Data for the commit |

## Verification
The hardest situations to reach are the ones where the master abandons a transfer partway through. One is a start that arrives partway through a byte; another is a missing acknowledge followed by more clocks before the stop. A third is a burst that crosses either the page boundary or the top of the array. The bench drives these directly with a bit-level master. It sends partial bytes before a repeated start, clocks a full silent byte after a missing acknowledge, and places page writes and sequential reads so that they straddle offset 15 and address 511. Each time, it then reads the counter back through a plain current-address read.

// File: rtl/eep2w_pkg.sv
package eep2w_pkg;
    localparam int MEM_AW = 9;
    localparam int BYTE_W = 8;
    localparam logic [3:0] TYPE_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } ctl_state_t;
endpackage

// File: rtl/eep2w_line_sync.sv
module eep2w_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = STAGES + 1;

    logic [1:0] line_in;
    logic [1:0] line_s;
    logic [1:0] line_d;

    assign line_in = {scl_i, sda_i};

    // one synchroniser chain per bus line, idle level is high
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [DEPTH-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[DEPTH-2:0], line_in[g]};
            end
        end
        assign line_s[g] = pipe[STAGES-1];
        assign line_d[g] = pipe[STAGES];
    end

    assign scl_s     = line_s[1];
    assign sda_s     = line_s[0];
    assign scl_rise  = line_s[1] & ~line_d[1];
    assign scl_fall  = ~line_s[1] & line_d[1];
    assign start_det = line_s[1] & line_d[1] & line_d[0] & ~line_s[0];
    assign stop_det  = line_s[1] & line_d[1] & ~line_d[0] & line_s[0];
endmodule

// File: rtl/eep2w_byte_shift.sv
module eep2w_byte_shift
    import eep2w_pkg::*;
#(
    parameter int WIDTH = BYTE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_clr,
    input  logic                       sample_en,
    input  logic                       sda_bit,
    input  logic                       tx_load,
    input  logic [WIDTH-1:0]           tx_data,
    input  logic                       tx_shift,
    output logic [WIDTH-1:0]           rx_byte,
    output logic                       tx_msb,
    output logic [$clog2(WIDTH+1)-1:0] bit_cnt,
    output logic                       byte_full
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] tx_reg;

    assign byte_full = (bit_cnt == CNT_W'(WIDTH));
    assign tx_msb    = tx_reg[WIDTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (bit_clr) begin
            bit_cnt <= '0;
        end else if (sample_en && !byte_full) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte <= '0;
        end else if (sample_en) begin
            rx_byte <= {rx_byte[WIDTH-2:0], sda_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_reg <= '1;
        end else if (tx_load) begin
            tx_reg <= tx_data;
        end else if (tx_shift) begin
            tx_reg <= {tx_reg[WIDTH-2:0], 1'b1};
        end
    end

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_en && tx_shift)) else $error("rise and fall together"); // R10
endmodule

// File: rtl/eep2w_addr_ctr.sv
module eep2w_addr_ctr #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] addr
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (inc_page) begin
            addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
        end else if (inc_full) begin
            addr <= addr + ADDR_W'(1);
        end
    end

    AST_PAGE_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !load) |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])))
        else $error("page row changed"); // R5

    AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_full && !load && !inc_page && (addr == {ADDR_W{1'b1}})) |=> (addr == '0))
        else $error("array wrap wrong"); // R8

    logic [ROW_W-1:0] unused_row;
    assign unused_row = addr[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/eep2w_slave.sv
module eep2w_slave
    import eep2w_pkg::*;
#(
    parameter int PAGE_AW     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_n,
    input  logic              strap_a2,
    input  logic              strap_a1,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              wr_en,
    output logic [MEM_AW-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    ctl_state_t state, nxt;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic tx_msb, byte_full;
    logic [CNT_W-1:0] bit_cnt;
    logic [MEM_AW-1:0] ctr_addr;

    logic bit_clr, sample_en, tx_load, tx_shift;
    logic ctr_load, inc_page, inc_full, commit, dev_done;
    logic dev_rw, dev_msb, mack;
    logic addr_match;

    eep2w_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep2w_byte_shift #(.WIDTH(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_clr(bit_clr), .sample_en(sample_en),
        .sda_bit(sda_s), .tx_load(tx_load), .tx_data(mem_rd_data), .tx_shift(tx_shift),
        .rx_byte(rx_byte), .tx_msb(tx_msb), .bit_cnt(bit_cnt), .byte_full(byte_full)
    );

    eep2w_addr_ctr #(.ADDR_W(MEM_AW), .PAGE_W(PAGE_AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val({dev_msb, rx_byte}),
        .inc_page(inc_page), .inc_full(inc_full), .addr(ctr_addr)
    );

    assign mem_rd_addr = ctr_addr;
    assign addr_match  = (rx_byte[7:4] == TYPE_CODE) && (rx_byte[3] == strap_a2)
                      && (rx_byte[2] == strap_a1);

    // receive-phase sampling on every SCL rise of a data bit
    always_comb begin
        unique case (state)
            ST_DEV, ST_WADDR, ST_WDATA, ST_RDATA: sample_en = scl_rise;
            default:                              sample_en = 1'b0;
        endcase
    end

    // next state and control strobes
    always_comb begin
        nxt      = state;
        bit_clr  = 1'b0;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        ctr_load = 1'b0;
        inc_page = 1'b0;
        inc_full = 1'b0;
        commit   = 1'b0;
        dev_done = 1'b0;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt     = ST_DEV;
            bit_clr = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nxt = ST_IDLE;
                end
                ST_DEV: begin
                    if (scl_fall && byte_full) begin
                        dev_done = addr_match;
                        nxt      = addr_match ? ST_DEV_ACK : ST_IDLE;
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        bit_clr = 1'b1;
                        if (dev_rw) begin
                            nxt     = ST_RDATA;
                            tx_load = 1'b1;
                        end else begin
                            nxt = ST_WADDR;
                        end
                    end
                end
                ST_WADDR: begin
                    if (scl_fall && byte_full) begin
                        nxt      = ST_WADDR_ACK;
                        ctr_load = 1'b1;
                    end
                end
                ST_WADDR_ACK: begin
                    if (scl_fall) begin
                        nxt     = ST_WDATA;
                        bit_clr = 1'b1;
                    end
                end
                ST_WDATA: begin
                    if (scl_fall && byte_full) begin
                        nxt      = ST_WDATA_ACK;
                        commit   = 1'b1;
                        inc_page = 1'b1;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        nxt     = ST_WDATA;
                        bit_clr = 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (byte_full) begin
                            nxt      = ST_RACK;
                            inc_full = 1'b1;
                        end else begin
                            tx_shift = 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        if (mack) begin
                            nxt     = ST_RDATA;
                            tx_load = 1'b1;
                            bit_clr = 1'b1;
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // captured device byte fields and master acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_rw  <= 1'b0;
            dev_msb <= 1'b0;
            mack    <= 1'b0;
        end else begin
            if (dev_done) begin
                dev_rw <= rx_byte[0];
                if (!rx_byte[0]) begin
                    dev_msb <= rx_byte[1];
                end
            end
            if (state == ST_RACK && scl_rise) begin
                mack <= ~sda_s;
            end
        end
    end

    // commit port toward the write engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= commit;
            if (commit) begin
                wr_addr <= ctr_addr;
                wr_data <= rx_byte;
            end
        end
    end

    // outputs: open-drain enable
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe_n = 1'b0;
            ST_RDATA:                               sda_oe_n = tx_msb;
            default:                                sda_oe_n = 1'b1;
        endcase
    end

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV && bit_cnt == '0)) else $error("start"); // R1

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && sda_oe_n)) else $error("stop"); // R1

    AST_NO_ACK_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && scl_fall && byte_full && !addr_match) |=> sda_oe_n)
        else $error("ack on mismatch"); // R3

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en) else $error("long strobe"); // R4

    AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_n) |-> !scl_s) else $error("drive while SCL high"); // R10
endmodule

// File: tb/eep2w_slave_bench.sv
module eep2w_slave_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe_n, wr_en;
    logic [8:0] mem_rd_addr, wr_addr;
    logic [7:0] mem_rd_data, wr_data;
    wire  sda_line = m_sda & sda_oe_n;
    localparam logic STRAP2 = 1'b1;
    localparam logic STRAP1 = 1'b0;
    localparam int Q = 6;

    logic [7:0] bmem [512];
    logic [7:0] exp_mem [512];
    logic [16:0] wq[$];
    int n_checks = 0;
    int n_fail = 0;
    int viol = 0;
    logic prev_oe = 1'b1;

    eep2w_slave u_eep2w_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_n(sda_oe_n),
        .strap_a2(STRAP2), .strap_a1(STRAP1), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign mem_rd_data = bmem[mem_rd_addr];

    initial begin
        for (int i = 0; i < 512; i++) begin
            bmem[i]    = 8'((i * 37 + 11) & 255);
            exp_mem[i] = 8'((i * 37 + 11) & 255);
        end
    end

    always @(posedge clk) if (wr_en) bmem[wr_addr] <= wr_data;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor for the commit port
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (wq.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R3/R7 unexpected write: actual %0h/%0h expected none",
                         wr_addr, wr_data);
            end else begin
                logic [16:0] e;
                e = wq.pop_front();
                chk("R4", "commit addr/data", {15'd0, wr_addr, wr_data}, {15'd0, e});
            end
        end
    end

    // R10: drive onset only while SCL low
    always @(negedge clk) begin
        if (rst_n && prev_oe && !sda_oe_n && m_scl) viol++;
        prev_oe <= sda_oe_n;
    end

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
        ack = ~sda_line;
        qw(); m_scl = 1'b0; qw();
    endtask

    task automatic rbyte(input logic macknow, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
            d[i] = sda_line;
            qw(); m_scl = 1'b0; qw();
        end
        send_bit(~macknow);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic b8, input logic rw);
        return {4'b1010, STRAP2, STRAP1, b8, rw};
    endfunction

    task automatic push_wr(input logic [8:0] a, input logic [7:0] d);
        wq.push_back({a, d});
        exp_mem[a] = d;
    endtask

    task automatic set_addr(input logic [8:0] a);
        logic ack;
        bus_start();
        wbyte(dev(a[8], 1'b0), ack); chk("R7", "dummy dev ack", ack, 1);
        wbyte(a[7:0], ack);          chk("R7", "dummy word ack", ack, 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        repeat (10) @(negedge clk);
        chk("R1", "reset sda_oe_n", sda_oe_n, 1);
        chk("R4", "reset wr_en", wr_en, 0);
        chk("R6", "reset counter", mem_rd_addr, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // byte write to 0x1A5
        bus_start();
        wbyte(dev(1'b1, 1'b0), ack); chk("R2", "dev ack", ack, 1);
        wbyte(8'hA5, ack);           chk("R4", "word ack", ack, 1);
        push_wr(9'h1A5, 8'h3C);
        wbyte(8'h3C, ack);           chk("R4", "data ack", ack, 1);
        bus_stop();
        repeat (20) @(negedge clk);
        chk("R4", "write queue drained", wq.size(), 0);

        // current-address read, bit 1 of device byte ignored
        bus_start();
        wbyte(dev(1'b0, 1'b1), ack); chk("R2", "read dev ack", ack, 1);
        rbyte(1'b0, d);              chk("R6", "current read 1A6", d, exp_mem[9'h1A6]);
        bus_stop();

        // random read of 0x1A5
        set_addr(9'h1A5);
        bus_start();
        wbyte(dev(1'b1, 1'b1), ack); chk("R7", "read dev ack", ack, 1);
        rbyte(1'b0, d);              chk("R7", "random read 1A5", d, 8'h3C);
        bus_stop();

        // page write wrapping inside the page
        bus_start();
        wbyte(dev(1'b0, 1'b0), ack);
        wbyte(8'hFD, ack);
        for (int k = 0; k < 5; k++) begin
            logic [3:0] off;
            off = 4'(4'hD + k);
            push_wr({5'h0F, off}, 8'(8'h50 + k));
            wbyte(8'(8'h50 + k), ack); chk("R5", "page data ack", ack, 1);
        end
        bus_stop();
        repeat (20) @(negedge clk);
        chk("R5", "page queue drained", wq.size(), 0);
        set_addr(9'h0F0);
        bus_start();
        wbyte(dev(1'b0, 1'b1), ack);
        rbyte(1'b1, d); chk("R5", "wrapped byte at 0F0", d, 8'h53);
        rbyte(1'b0, d); chk("R5", "wrapped byte at 0F1", d, 8'h54);
        bus_stop();

        // sequential read across the top of the array
        set_addr(9'h1FE);
        bus_start();
        wbyte(dev(1'b1, 1'b1), ack);
        rbyte(1'b1, d); chk("R8", "seq 1FE", d, exp_mem[9'h1FE]);
        rbyte(1'b1, d); chk("R8", "seq 1FF", d, exp_mem[9'h1FF]);
        rbyte(1'b1, d); chk("R8", "seq wrap 000", d, exp_mem[9'h000]);
        rbyte(1'b0, d); chk("R8", "seq 001", d, exp_mem[9'h001]);
        // no master ack: slave stays silent
        rbyte(1'b0, d); chk("R9", "silent after nack", d, 8'hFF);
        bus_stop();
        bus_start();
        wbyte(dev(1'b0, 1'b1), ack);
        rbyte(1'b0, d); chk("R9", "counter after nack", d, exp_mem[9'h002]);
        bus_stop();

        // mismatching device bytes
        bus_start();
        wbyte({4'b1010, ~STRAP2, STRAP1, 1'b0, 1'b0}, ack); chk("R3", "strap mismatch ack", ack, 0);
        wbyte(8'h10, ack); chk("R3", "ignored word ack", ack, 0);
        wbyte(8'h99, ack); chk("R3", "ignored data ack", ack, 0);
        bus_stop();
        bus_start();
        wbyte({4'b1011, STRAP2, STRAP1, 1'b0, 1'b1}, ack); chk("R3", "type mismatch ack", ack, 0);
        bus_stop();
        bus_start();
        wbyte(dev(1'b0, 1'b1), ack);
        rbyte(1'b0, d); chk("R3", "counter untouched", d, exp_mem[9'h003]);
        bus_stop();

        // start inside a device byte restarts reception
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        wbyte(dev(1'b0, 1'b1), ack); chk("R1", "ack after restart", ack, 1);
        rbyte(1'b0, d);              chk("R1", "read after restart", d, exp_mem[9'h004]);
        bus_stop();

        // start inside a data byte aborts the write
        bus_start();
        wbyte(dev(1'b0, 1'b0), ack);
        wbyte(8'h20, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        wbyte(dev(1'b1, 1'b1), ack); chk("R1", "ack after abort", ack, 1);
        rbyte(1'b0, d);              chk("R1", "aborted write kept addr", d, exp_mem[9'h020]);
        bus_stop();

        repeat (20) @(negedge clk);
        chk("R10", "drive onsets while SCL high", viol, 0);
        chk("R7", "no stray writes pending", wq.size(), 0);
        summary();
        $finish;
    end
endmodule